// File: doc/BRIEF.md
# Quaternary Two-Digit Counter from AB Storage Cells

This block counts from 0 to 15 on two radix-4 digits. Each digit is a value from 0 to 3 and sits on a 2-bit bus. Every digit is held in an AB storage cell whose next state is MAX(A, MIN(B, Q)). The A and B terms of each cell are built only from MIN, MAX, a one-step cyclic increment and two threshold functions. No complement of a digit is ever formed.

The least significant digit moves forward on every enabled clock. The upper digit moves forward only when every lower digit sits at 3. A low count enable makes every cell hold its value, by presenting A=0 and B=3 to it. A separate AB cell, with its own A and B pins, is brought out so that the storage rule can be driven directly. All cells share one clock and one synchronous reset. The outputs are plain status pins with no handshake.

Top module: `quat_ab_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both counter digits and the standalone cell become 0, and `tc` becomes 0.
- R2: Digits use unsigned binary codes 0..3. On each enabled clock the low digit `lsd` advances by one, and 3 wraps to 0.
- R3: On an enabled clock, `msd` advances by one (3 wraps to 0) only if `lsd` is 3. Otherwise it keeps its value.
- R4: Read as msd*4+lsd, the counter visits 0,1,...,15 in order and then returns to 0.
- R5: On a clock with `cnt_en` low, both `lsd` and `msd` keep their values.
- R6: `tc` is high exactly when `cnt_en` is high and both digits are 3.
- R7: At each rising edge the standalone cell loads MAX(`ab_a`, MIN(`ab_b`, `ab_q`)), comparing the codes as unsigned numbers.
- R8: The standalone cell keeps its value when `ab_a`=0 and `ab_b`=3, and copies `ab_a` when `ab_b`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; low holds both digits |
| lsd | output | 2 | Least significant quaternary digit |
| msd | output | 2 | Most significant quaternary digit |
| tc | output | 1 | Terminal count: enabled and state 33 |
| ab_a | input | 2 | A input of the standalone cell |
| ab_b | input | 2 | B input of the standalone cell |
| ab_q | output | 2 | State of the standalone cell |

## Verification
The hardest case to reach is the standalone cell with a chosen current state combined with an arbitrary A and B. The port has no load, so the bench first drives B=0 with A equal to the wanted state, which copies A into the cell. It then applies the A/B pair under test for one edge. This is repeated for all 64 combinations. The upper-digit carry is reached only after long enabled runs, so the bench counts past two wraps. It also drops the enable exactly in state 33 and in the states around it.

// File: rtl/qdigit_pkg.sv
package qdigit_pkg;
  localparam int QW = 2;
  localparam logic [QW-1:0] QTOP = '1;
  typedef logic [QW-1:0] qd_t;

  function automatic qd_t qmin(input qd_t x, input qd_t y);
    return (x < y) ? x : y;
  endfunction

  function automatic qd_t qmax(input qd_t x, input qd_t y);
    return (x > y) ? x : y;
  endfunction

  // one-step clockwise cyclic increment, top wraps to zero
  function automatic qd_t qinc(input qd_t x);
    return (x == QTOP) ? qd_t'(0) : qd_t'(x + 1'b1);
  endfunction

  // upper threshold: full level when x is at the top value
  function automatic qd_t thr_hi(input qd_t x);
    return (x >= QTOP) ? QTOP : qd_t'(0);
  endfunction

  // lower threshold: full level when x is below the top value
  function automatic qd_t thr_lo(input qd_t x);
    return (x <= QTOP - 1'b1) ? QTOP : qd_t'(0);
  endfunction
endpackage

// File: rtl/ab_cell.sv
module ab_cell
  import qdigit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  qd_t  a,
  input  qd_t  b,
  output qd_t  q
);
  qd_t nxt;
  assign nxt = qmax(a, qmin(b, q));

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (a == '0 && b == QTOP) |=> $stable(q)); // R8
  AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (b == '0) |=> (q == $past(a))); // R8
  AST_AB_FLOOR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q >= $past(a))); // R7
endmodule

// File: rtl/digit_drive.sv
module digit_drive
  import qdigit_pkg::*;
(
  input  qd_t  q,
  input  qd_t  hi_in,
  input  qd_t  lo_in,
  input  logic en,
  output qd_t  a_out,
  output qd_t  b_out,
  output qd_t  hi_out,
  output qd_t  lo_out
);
  qd_t run_lvl, hold_lvl, a_raw, b_raw;

  assign run_lvl  = en ? QTOP : qd_t'(0);
  assign hold_lvl = en ? qd_t'(0) : QTOP;

  assign a_raw = qmin(hi_in, qinc(q));
  assign b_raw = qmin(lo_in, q);

  // disabled: A forced to 0, B forced to full level -> hold
  assign a_out = qmin(a_raw, run_lvl);
  assign b_out = qmax(b_raw, hold_lvl);

  assign hi_out = qmin(hi_in, thr_hi(q));
  assign lo_out = qmax(lo_in, thr_lo(q));
endmodule

// File: rtl/quat_ab_counter.sv
module quat_ab_counter
  import qdigit_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  output logic [1:0] lsd,
  output logic [1:0] msd,
  output logic       tc,
  input  logic [1:0] ab_a,
  input  logic [1:0] ab_b,
  output logic [1:0] ab_q
);
  localparam int TOPD = NDIG - 1;

  qd_t dq [NDIG];
  qd_t da [NDIG];
  qd_t db [NDIG];
  qd_t hi_c [NDIG+1];
  qd_t lo_c [NDIG+1];

  assign hi_c[0] = QTOP;
  assign lo_c[0] = '0;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    digit_drive u_drv (
      .q(dq[k]), .hi_in(hi_c[k]), .lo_in(lo_c[k]), .en(cnt_en),
      .a_out(da[k]), .b_out(db[k]), .hi_out(hi_c[k+1]), .lo_out(lo_c[k+1])
    );
    ab_cell u_cell (.clk(clk), .rst(rst), .a(da[k]), .b(db[k]), .q(dq[k]));
  end

  ab_cell u_solo (.clk(clk), .rst(rst), .a(ab_a), .b(ab_b), .q(ab_q));

  assign lsd = dq[0];
  assign msd = dq[TOPD];
  assign tc  = (qmin(hi_c[NDIG], cnt_en ? QTOP : qd_t'(0)) == QTOP);

  AST_LSD_STEP: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (lsd == qinc($past(lsd)))); // R2
  AST_MSD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && lsd == QTOP) |=> (msd == qinc($past(msd)))); // R3
  AST_MSD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (lsd != QTOP) |=> $stable(msd)); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(lsd) && $stable(msd))); // R5
  AST_TC_STATE: assert property (@(posedge clk) disable iff (rst)
    tc |-> (cnt_en && lsd == QTOP && msd == QTOP)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (lsd == '0 && msd == '0 && ab_q == '0)); // R1
endmodule

// File: tb/sim_quat_ab_counter.sv
module sim_quat_ab_counter;
  logic clk = 0;
  logic rst = 1;
  logic cnt_en = 0;
  logic [1:0] lsd, msd, ab_a, ab_b, ab_q;
  logic tc;
  int errors = 0;
  int checks = 0;
  int ref_cnt = 0;

  always #4 clk = ~clk;

  quat_ab_counter u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .lsd(lsd), .msd(msd), .tc(tc),
    .ab_a(ab_a), .ab_b(ab_b), .ab_q(ab_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change at negedge, one edge, sample at next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_cnt(input string req);
    chk(req, int'(msd) * 4 + int'(lsd), ref_cnt);
    chk({req, " tc R6"}, int'(tc), int'(cnt_en && ref_cnt == 15));
  endtask

  task automatic t_reset();
    rst = 1; cnt_en = 1; ab_a = 2'd3; ab_b = 2'd3;
    tick(); tick();
    chk("R1 lsd", lsd, 0);
    chk("R1 msd", msd, 0);
    chk("R1 ab_q", ab_q, 0);
    cnt_en = 0;
    chk("R1 tc", tc, 0);
    rst = 0; ref_cnt = 0;
  endtask

  task automatic t_run(input int n);
    cnt_en = 1;
    for (int i = 0; i < n; i++) begin
      tick();
      ref_cnt = (ref_cnt + 1) % 16;
      chk_cnt("R2 R3 R4 count");
    end
  endtask

  task automatic t_toggle();
    for (int i = 0; i < 40; i++) begin
      cnt_en = (i % 3) != 1;
      #1;
      chk("R6 tc pre", int'(tc), int'(cnt_en && ref_cnt == 15));
      tick();
      if (cnt_en) ref_cnt = (ref_cnt + 1) % 16;
      chk_cnt("R5 enable toggle");
    end
  endtask

  task automatic t_hold_at_top();
    cnt_en = 1;
    while (ref_cnt != 15) begin tick(); ref_cnt = (ref_cnt + 1) % 16; end
    chk_cnt("R6 at 33");
    cnt_en = 0;
    #1;
    chk("R6 tc disabled at 33", tc, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_cnt("R5 hold at 33");
    end
    cnt_en = 1;
    tick(); ref_cnt = 0;
    chk_cnt("R4 wrap to 00");
  endtask

  task automatic t_ab_all();
    for (int q = 0; q < 4; q++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          int mn, ex;
          ab_a = 2'(q); ab_b = 2'd0;
          tick();
          chk("R8 load", ab_q, q);
          ab_a = 2'(a); ab_b = 2'(b);
          tick();
          mn = (b < q) ? b : q;
          ex = (a > mn) ? a : mn;
          chk("R7 ab rule", ab_q, ex);
        end
  endtask

  task automatic t_ab_hold();
    ab_a = 2'd2; ab_b = 2'd0; tick();
    ab_a = 2'd0; ab_b = 2'd3;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 hold", ab_q, 2);
    end
    ab_a = 2'd1; ab_b = 2'd2; ab_b = 2'd2;
    ab_a = 2'd3; ab_b = 2'd0; tick();
    ab_a = 2'd1; ab_b = 2'd2; tick();
    chk("R7 example 1,2,3", ab_q, 2);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ab_a = 0; ab_b = 0;
    @(negedge clk);
    t_reset();
    t_run(40);
    t_toggle();
    t_hold_at_top();
    t_ab_all();
    t_ab_hold();
    rst = 1; tick();
    chk("R1 reset again", int'(msd) * 4 + int'(lsd), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule